// File: doc/BRIEF.md
# Two-Stage Watchdog with Register Window

This block is a watchdog timer reached through a 32-byte little-endian register window on a simple byte-addressed bus. The bus presents a word address, two byte enables and write data in one cycle. Reads are combinational from the address. Software loads a 10-bit period value and starts the countdown by writing the first control register or the reload register. A prescaler divides the clock into coarse ticks of `TICK_CYCLES` clock cycles, about 0.6 s in a real system. When the count runs out, the block sets a timeout status bit and emits a one-cycle SMI or NMI pulse. The choice between them follows a route-enable bit that the block holds for a neighbouring SMI-enable register. If a second expiry follows with no reload in between, the block also marks second-timeout and boot status. When the no-reboot input is low, it then requests a system reset and halts instead of signalling.

The window also holds a mailbox. A data-in write raises status and an SMI; a data-out write raises status only. It further holds a second control register, message bytes, a watchdog-count byte and a software interrupt byte. A lock bit in the first control register is sticky until reset. Once set, it freezes both itself and the route-enable bit.

The timer is a state machine with three states:
- `ST_IDLE`: the timer is stopped.
- `ST_COUNT`: ticks decrement the remaining count.
- `ST_EXPIRE`: a one-cycle state in which the pulse for an expiry is issued.

It has these transitions:
- *start*: any state to `ST_COUNT`, on a qualifying control or reload write.
- *stop*: any state to `ST_IDLE`, on a control write that leaves the timer unable to run.
- *run-out*: `ST_COUNT` to `ST_EXPIRE`, on the tick that finds one or zero ticks left.
- *rearm*: `ST_EXPIRE` to `ST_COUNT`, when no reset is requested.
- *reboot*: `ST_EXPIRE` to `ST_IDLE`, when the second expiry requests a reset.

A start or stop command wins over the other transitions in the same cycle.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the words read back as follows: period (offset 0x12) 0x0004, control-B (0x0A) 0x0008, soft-IRQ byte (0x10) 0x0003. Every other word reads 0, and the smi_o, nmi_o, rst_req_o and route_en_o outputs are low.
- R2: Words sit at even offsets, and writes and reads use the word at bus_addr. bus_be[0] writes bits 7:0 and bus_be[1] writes bits 15:8. The words and their offsets are:
  - 0x00: reload
  - 0x02: mailbox, with data-in in bits 7:0 and data-out in bits 15:8
  - 0x04: status-A
  - 0x06: status-B
  - 0x08: control-A
  - 0x0A: control-B
  - 0x0C: message
  - 0x0E: watchdog-count byte
  - 0x10: soft-IRQ byte
  - 0x12: period
  
  A write with both enables low changes nothing.
- R3: The timer can run only when control-A bit 11 (halt) is 0 and period bits 9:0 exceed 1. A period of 0 or 1 (including 0x0400) never starts it.
- R4: A write to reload clears the consecutive-expiry count. If the timer can run, the write restarts it and reload takes the period value. Otherwise the written data is stored in reload.
- R5: Control-A writes are masked with 0xFEFF. Bit 12 (lock) cannot be cleared by software, only by reset. Each control-A write restarts the timer (reload takes the period) if it can run, and stops it otherwise.
- R6: With period N and tick length T, the first expiry pulse is high in the cycle after clock edge k+N*T, where k is the edge that sampled the starting write. Further expiries follow every N*T+1 cycles.
- R7: Every expiry sets status-A bit 3. An expiry that does not request a reset pulses smi_o if route_en_o is 1, and nmi_o otherwise, and then the timer rearms.
- R8: A second consecutive expiry sets status-B bits 1 and 2 and returns the expiry count to 0. With no_reboot low, it pulses rst_req_o instead of smi_o or nmi_o, stops the timer, and reload reads 0. With no_reboot high, it behaves as in R7.
- R9: A data-in byte write stores the byte, sets status-A bit 1 and pulses smi_o in the cycle after the write edge. A data-out byte write stores the byte and sets status-A bit 2.
- R10: A status-A write replaces the enabled bytes with the data masked by 0xE870. A status-B write does the same with the mask 0xFFF8.
- R11: A route_we pulse loads route_wdata into route_en_o, except while the lock bit is 1, when the write is ignored.
- R12: While the timer runs, reload reads back as the remaining tick count in bits 9:0, with the stored reload bits 15:10 above it.
- R13: smi_o, nmi_o and rst_req_o pulses caused by an expiry last one cycle, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 5 | Byte offset of the word accessed (even) |
| bus_be | input | 2 | Byte enables, bit 0 for the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| route_we | input | 1 | Write strobe from the neighbouring SMI-enable register |
| route_wdata | input | 1 | New value of the route-enable bit |
| no_reboot | input | 1 | When high, a second expiry does not request reset |
| route_en_o | output | 1 | Current route-enable bit (1 selects SMI on expiry) |
| smi_o | output | 1 | One-cycle SMI pulse |
| nmi_o | output | 1 | One-cycle NMI pulse |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions take three things for granted about the bus:
- the address is even;
- the upper lane of a byte-wide register is never relied upon;
- no start or stop command lands in the same cycle as an expiry, apart from the case the reset-stop property already excludes.

The stimulus keeps within this. It issues every bus write on the falling edge and holds it for a single cycle. It also times each timer test so that writes fall between expiries, never on the expiry cycle itself.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_MBOX   = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_STAT_A = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT_B = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL_A = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL_B = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_MSG    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_WDCNT  = 5'h0E;
    localparam logic [ADDR_W-1:0] OFS_SWIRQ  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 5'h12;

    localparam logic [WORD_W-1:0] MASK_STAT_A = 16'hE870;
    localparam logic [WORD_W-1:0] MASK_STAT_B = 16'hFFF8;
    localparam logic [WORD_W-1:0] MASK_CTRL_A = 16'hFEFF;

    localparam logic [WORD_W-1:0] RST_PERIOD = 16'h0004;
    localparam logic [WORD_W-1:0] RST_CTRL_B = 16'h0008;
    localparam logic [7:0]        RST_SWIRQ  = 8'h03;

    localparam int BIT_HALT     = 11;
    localparam int BIT_LOCK     = 12;
    localparam int BIT_TIMEOUT  = 3;
    localparam int BIT_MBOX_IN  = 1;
    localparam int BIT_MBOX_OUT = 2;
    localparam int BIT_SECOND   = 1;
    localparam int BIT_BOOT     = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_EXPIRE = 2'd2
    } wd_state_e;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] nxt,
        input logic [1:0]        be
    );
        logic [WORD_W-1:0] res;
        res = cur;
        for (int l = 0; l < 2; l++) begin
            if (be[l]) res[l*8 +: 8] = nxt[l*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICK_CYCLES = 120_000_000,
    parameter int PERIOD_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cmd_stop,
    input  logic                clr_strike,
    input  logic [PERIOD_W-1:0] period,
    input  logic                no_reboot,
    input  logic                route_en,
    output logic                running,
    output logic [PERIOD_W-1:0] remain,
    output logic                fire,
    output logic                fire_second,
    output logic                fire_reset,
    output logic                smi_o,
    output logic                nmi_o,
    output logic                rst_req_o
);

    localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    wd_state_e           st_q, st_d;
    logic [PRE_W-1:0]    pre_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic                strike_q;
    logic                tick, last, load;

    assign tick        = (st_q == ST_COUNT) && (pre_q == PRE_LAST);
    assign last        = (cnt_q <= PERIOD_W'(1));
    assign fire        = (st_q == ST_EXPIRE);
    assign fire_second = fire && strike_q;
    assign fire_reset  = fire_second && !no_reboot;
    assign load        = cmd_start || (fire && !fire_reset && !cmd_stop);
    assign running     = (st_q != ST_IDLE);
    assign remain      = cnt_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = ST_IDLE;
            ST_COUNT:  if (tick && last) st_d = ST_EXPIRE;
            ST_EXPIRE: st_d = fire_reset ? ST_IDLE : ST_COUNT;
            default:   st_d = ST_IDLE;
        endcase
        if (cmd_start)     st_d = ST_COUNT;
        else if (cmd_stop) st_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // countdown datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            cnt_q    <= '0;
            strike_q <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= period;
                pre_q <= '0;
            end else if (tick) begin
                pre_q <= '0;
                if (!last) cnt_q <= cnt_q - PERIOD_W'(1);
            end else if (st_q == ST_COUNT) begin
                pre_q <= pre_q + PRE_W'(1);
            end
            if (clr_strike) strike_q <= 1'b0;
            else if (fire)  strike_q <= !strike_q;
        end
    end

    // outputs
    always_comb begin
        smi_o     = fire && !fire_reset && route_en;
        nmi_o     = fire && !fire_reset && !route_en;
        rst_req_o = fire_reset;
    end

    p_pulse_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smi_o, nmi_o, rst_req_o}));
    p_pulse_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_o || nmi_o || rst_req_o) |=> !(smi_o || nmi_o || rst_req_o));
    p_stop_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && !cmd_start) |=> !running);
    p_no_small_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!running || ($past(period) > PERIOD_W'(1))));

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int PERIOD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_be,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                route_we,
    input  logic                route_wdata,
    input  logic                running,
    input  logic [PERIOD_W-1:0] remain,
    input  logic                fire,
    input  logic                fire_second,
    input  logic                fire_reset,
    output logic [PERIOD_W-1:0] period,
    output logic                cmd_start,
    output logic                cmd_stop,
    output logic                clr_strike,
    output logic                route_en,
    output logic                mbox_smi
);

    logic [WORD_W-1:0] reload_q, mbox_q, stat_a_q, stat_b_q;
    logic [WORD_W-1:0] ctrl_a_q, ctrl_b_q, msg_q, period_q;
    logic [7:0]        wdcnt_q, swirq_q;
    logic              route_q, mbox_smi_q;

    logic              any_be;
    logic              wr_reload, wr_mbox, wr_stat_a, wr_stat_b, wr_ctrl_a;
    logic              wr_ctrl_b, wr_msg, wr_wdcnt, wr_swirq, wr_period;
    logic              din_wr, dout_wr;
    logic [WORD_W-1:0] ctrl_a_new;
    logic              may_run_now, may_run_new;

    assign any_be    = |bus_be;
    assign wr_reload = bus_we && any_be && (bus_addr == OFS_RELOAD);
    assign wr_mbox   = bus_we && any_be && (bus_addr == OFS_MBOX);
    assign wr_stat_a = bus_we && any_be && (bus_addr == OFS_STAT_A);
    assign wr_stat_b = bus_we && any_be && (bus_addr == OFS_STAT_B);
    assign wr_ctrl_a = bus_we && any_be && (bus_addr == OFS_CTRL_A);
    assign wr_ctrl_b = bus_we && any_be && (bus_addr == OFS_CTRL_B);
    assign wr_msg    = bus_we && any_be && (bus_addr == OFS_MSG);
    assign wr_wdcnt  = bus_we && bus_be[0] && (bus_addr == OFS_WDCNT);
    assign wr_swirq  = bus_we && bus_be[0] && (bus_addr == OFS_SWIRQ);
    assign wr_period = bus_we && any_be && (bus_addr == OFS_PERIOD);
    assign din_wr    = wr_mbox && bus_be[0];
    assign dout_wr   = wr_mbox && bus_be[1];

    assign ctrl_a_new  = (lane_merge(ctrl_a_q, bus_wdata, bus_be) & MASK_CTRL_A)
                       | (ctrl_a_q & (WORD_W'(1) << BIT_LOCK));
    assign period      = period_q[PERIOD_W-1:0];
    assign may_run_now = !ctrl_a_q[BIT_HALT] && (period > PERIOD_W'(1));
    assign may_run_new = !ctrl_a_new[BIT_HALT] && (period > PERIOD_W'(1));

    assign cmd_start  = (wr_reload && may_run_now) || (wr_ctrl_a && may_run_new);
    assign cmd_stop   = wr_ctrl_a && !may_run_new;
    assign clr_strike = wr_reload;
    assign route_en   = route_q;
    assign mbox_smi   = mbox_smi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q   <= '0;
            mbox_q     <= '0;
            stat_a_q   <= '0;
            stat_b_q   <= '0;
            ctrl_a_q   <= '0;
            ctrl_b_q   <= RST_CTRL_B;
            msg_q      <= '0;
            wdcnt_q    <= '0;
            swirq_q    <= RST_SWIRQ;
            period_q   <= RST_PERIOD;
            route_q    <= 1'b0;
            mbox_smi_q <= 1'b0;
        end else begin
            // reload word: bus write first, expiry update otherwise
            if (wr_reload)
                reload_q <= may_run_now ? period_q
                                        : lane_merge(reload_q, bus_wdata, bus_be);
            else if (wr_ctrl_a && may_run_new)
                reload_q <= period_q;
            else if (fire)
                reload_q <= fire_reset ? '0 : period_q;

            if (wr_mbox)   mbox_q   <= lane_merge(mbox_q, bus_wdata, bus_be);
            if (wr_ctrl_a) ctrl_a_q <= ctrl_a_new;
            if (wr_ctrl_b) ctrl_b_q <= lane_merge(ctrl_b_q, bus_wdata, bus_be);
            if (wr_msg)    msg_q    <= lane_merge(msg_q, bus_wdata, bus_be);
            if (wr_wdcnt)  wdcnt_q  <= bus_wdata[7:0];
            if (wr_swirq)  swirq_q  <= bus_wdata[7:0];
            if (wr_period) period_q <= lane_merge(period_q, bus_wdata, bus_be);

            // status words: masked software write, then hardware set bits
            begin
                logic [WORD_W-1:0] sa, sb;
                sa = wr_stat_a ? lane_merge(stat_a_q, bus_wdata & MASK_STAT_A, bus_be)
                               : stat_a_q;
                sb = wr_stat_b ? lane_merge(stat_b_q, bus_wdata & MASK_STAT_B, bus_be)
                               : stat_b_q;
                if (fire)    sa[BIT_TIMEOUT]  = 1'b1;
                if (din_wr)  sa[BIT_MBOX_IN]  = 1'b1;
                if (dout_wr) sa[BIT_MBOX_OUT] = 1'b1;
                if (fire_second) begin
                    sb[BIT_SECOND] = 1'b1;
                    sb[BIT_BOOT]   = 1'b1;
                end
                stat_a_q <= sa;
                stat_b_q <= sb;
            end

            if (route_we && !ctrl_a_q[BIT_LOCK]) route_q <= route_wdata;
            mbox_smi_q <= din_wr;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RELOAD: bus_rdata = running ? {reload_q[WORD_W-1:PERIOD_W], remain}
                                            : reload_q;
            OFS_MBOX:   bus_rdata = mbox_q;
            OFS_STAT_A: bus_rdata = stat_a_q;
            OFS_STAT_B: bus_rdata = stat_b_q;
            OFS_CTRL_A: bus_rdata = ctrl_a_q;
            OFS_CTRL_B: bus_rdata = ctrl_b_q;
            OFS_MSG:    bus_rdata = msg_q;
            OFS_WDCNT:  bus_rdata = {8'h00, wdcnt_q};
            OFS_SWIRQ:  bus_rdata = {8'h00, swirq_q};
            OFS_PERIOD: bus_rdata = period_q;
            default:    bus_rdata = '0;
        endcase
    end

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_a_q[BIT_LOCK] |=> ctrl_a_q[BIT_LOCK]);
    p_route_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_a_q[BIT_LOCK] |=> $stable(route_q));
    p_timeout_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> stat_a_q[BIT_TIMEOUT]);

endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import wdog_pkg::*;
#(
    parameter int TICK_CYCLES = 120_000_000,
    parameter int PERIOD_W    = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        route_we,
    input  logic        route_wdata,
    input  logic        no_reboot,
    output logic        route_en_o,
    output logic        smi_o,
    output logic        nmi_o,
    output logic        rst_req_o
);

    logic [PERIOD_W-1:0] period, remain;
    logic cmd_start, cmd_stop, clr_strike, running;
    logic fire, fire_second, fire_reset, timer_smi, mbox_smi;

    wdog_regs #(.PERIOD_W(PERIOD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_be      (bus_be),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .route_we    (route_we),
        .route_wdata (route_wdata),
        .running     (running),
        .remain      (remain),
        .fire        (fire),
        .fire_second (fire_second),
        .fire_reset  (fire_reset),
        .period      (period),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .clr_strike  (clr_strike),
        .route_en    (route_en_o),
        .mbox_smi    (mbox_smi)
    );

    wdog_timer #(.TICK_CYCLES(TICK_CYCLES), .PERIOD_W(PERIOD_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .clr_strike  (clr_strike),
        .period      (period),
        .no_reboot   (no_reboot),
        .route_en    (route_en_o),
        .running     (running),
        .remain      (remain),
        .fire        (fire),
        .fire_second (fire_second),
        .fire_reset  (fire_reset),
        .smi_o       (timer_smi),
        .nmi_o       (nmi_o),
        .rst_req_o   (rst_req_o)
    );

    assign smi_o = timer_smi || mbox_smi;

endmodule

// File: tb/twostage_wdog_tb_top.sv
`timescale 1ns/1ps
module twostage_wdog_tb_top;

    localparam int TICK = 4;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        route_we = 1'b0;
    logic        route_wdata = 1'b0;
    logic        no_reboot = 1'b1;
    logic        route_en_o, smi_o, nmi_o, rst_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    twostage_wdog #(.TICK_CYCLES(TICK)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .route_we(route_we), .route_wdata(route_wdata), .no_reboot(no_reboot),
        .route_en_o(route_en_o), .smi_o(smi_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
    );

    // {waddr, be, wdata, raddr, expected}
    localparam logic [43:0] VEC_TBL [NVEC] = '{
        {5'h08, 2'd3, 16'h0FFF, 5'h08, 16'h0EFF},  // R5 mask
        {5'h0A, 2'd1, 16'h1234, 5'h0A, 16'h0034},  // R2 low lane
        {5'h0A, 2'd2, 16'hAB00, 5'h0A, 16'hAB34},  // R2 high lane
        {5'h0C, 2'd3, 16'h5A3C, 5'h0C, 16'h5A3C},
        {5'h0E, 2'd1, 16'h0077, 5'h0E, 16'h0077},
        {5'h10, 2'd1, 16'h00C5, 5'h10, 16'h00C5},
        {5'h12, 2'd3, 16'h0123, 5'h12, 16'h0123},
        {5'h04, 2'd3, 16'hFFFF, 5'h04, 16'hE870},  // R10
        {5'h06, 2'd3, 16'hFFFF, 5'h06, 16'hFFF8},  // R10
        {5'h04, 2'd3, 16'h0000, 5'h04, 16'h0000},
        {5'h06, 2'd3, 16'h0000, 5'h06, 16'h0000},
        {5'h00, 2'd3, 16'hBEEF, 5'h00, 16'hBEEF},  // R4 stored while halted
        {5'h02, 2'd2, 16'h9900, 5'h04, 16'h0004},  // R9 data-out
        {5'h02, 2'd1, 16'h0042, 5'h02, 16'h9942},  // R9 data-in
        {5'h04, 2'd0, 16'h0000, 5'h04, 16'h0006},  // R2 no enables
        {5'h04, 2'd3, 16'h0000, 5'h04, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [1:0] b, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = 2'b00;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // counts falling edges until an expiry pulse, then one more edge
    task automatic wait_pulse(input int start_k, output int k,
                              output logic [2:0] which, output logic [2:0] after);
        k = start_k;
        which = 3'b000;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            k++;
            if (smi_o || nmi_o || rst_req_o) begin
                which = {rst_req_o, nmi_o, smi_o};
                break;
            end
        end
        @(negedge clk);
        after = {rst_req_o, nmi_o, smi_o};
    endtask

    task automatic quiet(input string tag, input int cycles);
        logic seen;
        seen = 1'b0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            if (smi_o || nmi_o || rst_req_o) seen = 1'b1;
        end
        chk(tag, {15'd0, seen}, 16'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int          k;
        logic [2:0]  which, after;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(5'h12, v); chk("R1 period", v, 16'h0004);
        bus_rd(5'h0A, v); chk("R1 ctrl_b", v, 16'h0008);
        bus_rd(5'h10, v); chk("R1 swirq", v, 16'h0003);
        bus_rd(5'h08, v); chk("R1 ctrl_a", v, 16'h0000);
        bus_rd(5'h00, v); chk("R1 reload", v, 16'h0000);
        bus_rd(5'h04, v); chk("R1 stat_a", v, 16'h0000);
        bus_rd(5'h06, v); chk("R1 stat_b", v, 16'h0000);
        bus_rd(5'h02, v); chk("R1 mbox", v, 16'h0000);
        bus_rd(5'h0C, v); chk("R1 msg", v, 16'h0000);
        bus_rd(5'h0E, v); chk("R1 wdcnt", v, 16'h0000);
        chk("R1 outputs", {12'd0, route_en_o, smi_o, nmi_o, rst_req_o}, 16'd0);

        // register table (R2 R4 R5 R9 R10)
        for (int i = 0; i < NVEC; i++) begin
            bus_wr(VEC_TBL[i][43:39], VEC_TBL[i][38:37], VEC_TBL[i][36:21]);
            bus_rd(VEC_TBL[i][20:16], v);
            chk($sformatf("R2 table vec %0d", i), v, VEC_TBL[i][15:0]);
        end

        // R9 data-in SMI pulse, one cycle
        bus_wr(5'h02, 2'd1, 16'h0011);
        chk("R9 mailbox smi high", {15'd0, smi_o}, 16'd1);
        @(negedge clk);
        chk("R9 mailbox smi low", {15'd0, smi_o}, 16'd0);
        bus_rd(5'h04, v); chk("R9 status in bit", v, 16'h0002);
        bus_wr(5'h04, 2'd3, 16'h0000);

        // timer A: NMI route, no_reboot high
        bus_wr(5'h12, 2'd3, 16'h0402);
        bus_wr(5'h08, 2'd3, 16'h0000);
        bus_rd(5'h00, v); chk("R12 readback start", v, 16'h0402);
        repeat (4) @(negedge clk);
        bus_rd(5'h00, v); chk("R12 readback mid", v, 16'h0401);
        wait_pulse(4, k, which, after);
        chk("R6 first expiry cycle", 16'(k), 16'(2 * TICK));
        chk("R7 nmi route", {13'd0, which}, 16'h0002);
        chk("R13 single cycle", {13'd0, after}, 16'h0000);
        bus_rd(5'h04, v); chk("R7 timeout status", v, 16'h0008);
        wait_pulse(1, k, which, after);
        chk("R6 second expiry cycle", 16'(k), 16'(2 * TICK + 1));
        chk("R8 no_reboot keeps nmi", {13'd0, which}, 16'h0002);
        bus_rd(5'h06, v); chk("R8 second status", v, 16'h0006);
        wait_pulse(1, k, which, after);
        chk("R8 count restarts", {13'd0, which}, 16'h0002);
        bus_wr(5'h08, 2'd3, 16'h0800);
        bus_wr(5'h04, 2'd3, 16'h0000);
        bus_wr(5'h06, 2'd3, 16'h0000);

        // R11 route write while unlocked
        @(negedge clk); route_we = 1'b1; route_wdata = 1'b1;
        @(negedge clk); route_we = 1'b0;
        chk("R11 route set", {15'd0, route_en_o}, 16'd1);

        // timer B: SMI route, reset escalation, reload clears count (R4)
        no_reboot = 1'b0;
        bus_wr(5'h08, 2'd3, 16'h0000);
        bus_wr(5'h00, 2'd3, 16'h0000);
        wait_pulse(0, k, which, after);
        chk("R4 reload restart cycle", 16'(k), 16'(2 * TICK));
        chk("R7 smi route", {13'd0, which}, 16'h0001);
        wait_pulse(1, k, which, after);
        chk("R8 reset cycle", 16'(k), 16'(2 * TICK + 1));
        chk("R8 reset request", {13'd0, which}, 16'h0004);
        quiet("R8 stopped", 30);
        bus_rd(5'h00, v); chk("R8 reload zero", v, 16'h0000);
        bus_rd(5'h06, v); chk("R8 status b", v, 16'h0006);

        // R3 small period and halt never run
        bus_wr(5'h12, 2'd3, 16'h0001);
        bus_wr(5'h08, 2'd3, 16'h0000);
        quiet("R3 period one", 40);
        bus_wr(5'h12, 2'd3, 16'h0400);
        bus_wr(5'h08, 2'd3, 16'h0000);
        quiet("R3 period masked zero", 40);
        bus_wr(5'h12, 2'd3, 16'h0002);
        bus_wr(5'h08, 2'd3, 16'h0800);
        quiet("R3 halted", 40);

        // R5 lock sticky, R11 route frozen
        bus_wr(5'h08, 2'd3, 16'h1800);
        bus_rd(5'h08, v); chk("R5 lock set", v, 16'h1800);
        bus_wr(5'h08, 2'd3, 16'h0800);
        bus_rd(5'h08, v); chk("R5 lock sticky", v, 16'h1800);
        @(negedge clk); route_we = 1'b1; route_wdata = 1'b0;
        @(negedge clk); route_we = 1'b0;
        chk("R11 route frozen", {15'd0, route_en_o}, 16'd1);

        // R1 reset clears lock
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(5'h08, v); chk("R1 lock cleared", v, 16'h0000);
        bus_rd(5'h12, v); chk("R1 period again", v, 16'h0004);
        chk("R1 route cleared", {15'd0, route_en_o}, 16'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule